// File: doc/BRIEF.md
# PHY Basic Status Register with Override-Gated Bits

This block holds the basic status word of an Ethernet PHY management register file together with the one control bit that unlocks part of it. A management agent reaches it through a plain register port. The port has an address, write data, a write strobe, a read strobe and registered read data. Most of the status word is a fixed capability pattern. Five bits in the middle of the word are normally read-only, and they accept writes only while an override flag in a control register is set. The lowest of those five bits reports whether management frames without a preamble are accepted. Its stored value also drives an enable output toward the serial management frame logic.

The negotiation-done bit is a latching-high flag. It is set by the auto-negotiation engine's completion indication while negotiation is enabled. It keeps its value through a negotiation restart and through a drop of the completion indication. It is released only by a read of the status word. That read returns the held value and then reloads the flag from the live condition, so a second read reports the present state. While negotiation is disabled the bit always reads zero.

Top module: `physt_regfile`

## Requirements
- R1: While `rst_n` is low, every stored bit returns to zero: the override flag, the five gated bits, the done flag and the read-data register. `pre_suppr_en` is therefore 0 in reset.
- R2: In the control register (address CTL_ADDR, default 16), bit 15 is the override flag. Writes set and clear it freely and reads return it. All other bits of that register read zero.
- R3: While the override flag is 0, a write to the status register (address STS_ADDR, default 1) leaves bits 10:6 unchanged.
- R4: While the override flag is 1, a write to the status register loads bits 10:6 from the write data. Bit 6 is the preamble-suppression ability bit, and `pre_suppr_en` equals its stored value.
- R5: Status bits 15:11 and 4:0 always read the parameter STS_FIXED in those positions, whatever is written.
- R6: Status bit 5 reads zero in any read taken while `an_enable` is low.
- R7: The done flag sets in any cycle where `an_enable` and `an_complete` are both high. Once set, it stays set, even after `an_complete` falls, until the status register is read.
- R8: A pulse on `an_restart` never clears the done flag.
- R9: A status read returns the done flag held before the read, then reloads the flag from the live condition (`an_enable & an_complete`) of the read cycle. A completion in the same cycle as the read therefore leaves the flag set, and a second read reports the live state.
- R10: Read data is updated on the clock edge that samples `reg_rd` and holds until the next read. A read of any address other than the two mapped ones returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 16 | Registered read data |
| an_enable | input | 1 | Auto-negotiation enabled level |
| an_complete | input | 1 | Live negotiation-complete indication |
| an_restart | input | 1 | Negotiation restart pulse |
| pre_suppr_en | output | 1 | Accept management frames without a preamble |

## Verification
The bench builds the block with its defaults: a 5-bit address, the status word at address 1, the control word at address 16, and a fixed pattern of 16'h7809. These are the positions a management agent expects, so the random address mix also reaches unmapped addresses next to both registers. Because completion pulses, restarts, disable periods and reads are interleaved freely, the runs hit reads that coincide with a completion. They also hit reads taken while negotiation is disabled over a set flag, and gated writes issued just before and just after the override flag changes.

// File: rtl/physt_pkg.sv
package physt_pkg;

  localparam int unsigned REG_W       = 16;
  localparam int unsigned OVR_BIT     = 15;
  localparam int unsigned GATED_MSB   = 10;
  localparam int unsigned GATED_LSB   = 6;
  localparam int unsigned GATED_W     = GATED_MSB - GATED_LSB + 1;
  localparam int unsigned DONE_BIT    = 5;
  localparam logic [REG_W-1:0] LIVE_MASK = 16'h07E0;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STS  = 2'd1,
    SEL_CTL  = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/physt_decode.sv
module physt_decode
  import physt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned STS_ADDR = 1,
  parameter int unsigned CTL_ADDR = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output reg_sel_e          sel,
  output logic              wr_sts,
  output logic              wr_ctl,
  output logic              rd_sts
);

  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_ADDR);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);

  always_comb begin
    sel = SEL_NONE;
    if (addr == STS_A) begin
      sel = SEL_STS;
    end else if (addr == CTL_A) begin
      sel = SEL_CTL;
    end
  end

  assign wr_sts = wr && (sel == SEL_STS);
  assign wr_ctl = wr && (sel == SEL_CTL);
  assign rd_sts = rd && (sel == SEL_STS);

endmodule

// File: rtl/physt_ovr_bit.sv
module physt_ovr_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctl,
  input  logic wbit,
  output logic ovr_q
);

  logic ovr_d;

  always_comb begin
    ovr_d = ovr_q;
    if (wr_ctl) begin
      ovr_d = wbit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else if (wr_ctl) begin
      ovr_q <= ovr_d;
    end
  end

  AST_OVR_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (ovr_q == $past(wbit)))
    else $error("override flag did not take written value"); // R2

endmodule

// File: rtl/physt_gated_field.sv
module physt_gated_field #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_sts,
  input  logic         ovr_q,
  input  logic [W-1:0] wfield,
  output logic [W-1:0] field_q
);

  logic wr_ok;
  assign wr_ok = wr_sts && ovr_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic bit_d;

    always_comb begin
      bit_d = field_q[b];
      if (wr_ok) begin
        bit_d = wfield[b];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        field_q[b] <= 1'b0;
      end else if (wr_ok) begin
        field_q[b] <= bit_d;
      end
    end
  end

  AST_GATED_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_sts && ovr_q) |=> $stable(field_q))
    else $error("gated bits changed without override write"); // R3

  AST_GATED_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && ovr_q) |=> (field_q == $past(wfield)))
    else $error("gated bits missed an override write"); // R4

endmodule

// File: rtl/physt_done_latch.sv
module physt_done_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic an_en,
  input  logic an_done,
  input  logic an_restart,
  input  logic rd_sts,
  output logic done_q
);

  logic live;
  logic done_d;
  logic unused_restart;

  assign live = an_en && an_done;
  assign unused_restart = an_restart;

  always_comb begin
    if (rd_sts) begin
      done_d = live;
    end else begin
      done_d = done_q || live;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (an_en && an_done) |=> done_q)
    else $error("done flag failed to set"); // R7

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !rd_sts) |=> done_q)
    else $error("done flag dropped without a read"); // R7

  AST_RESTART_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (an_restart && done_q && !rd_sts) |=> done_q)
    else $error("restart cleared done flag"); // R8

  AST_READ_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sts && !(an_en && an_done)) |=> !done_q)
    else $error("done flag not reloaded from live state"); // R9

endmodule

// File: rtl/physt_regfile.sv
module physt_regfile
  import physt_pkg::*;
#(
  parameter int unsigned      ADDR_W    = 5,
  parameter int unsigned      STS_ADDR  = 1,
  parameter int unsigned      CTL_ADDR  = 16,
  parameter logic [REG_W-1:0] STS_FIXED = 16'h7809
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              an_enable,
  input  logic              an_complete,
  input  logic              an_restart,
  output logic              pre_suppr_en
);

  localparam logic [REG_W-1:0] FIXED_PART = STS_FIXED & ~LIVE_MASK;

  reg_sel_e               sel;
  logic                   wr_sts;
  logic                   wr_ctl;
  logic                   rd_sts;
  logic                   ovr_q;
  logic [GATED_W-1:0]     gated_q;
  logic                   done_q;
  logic [REG_W-1:0]       sts_word;
  logic [REG_W-1:0]       ctl_word;
  logic [REG_W-1:0]       rdata_d;
  logic                   unused_wdata_bits;

  assign unused_wdata_bits = ^{reg_wdata[OVR_BIT-1:GATED_MSB+1], reg_wdata[GATED_LSB-1:0]};

  physt_decode #(
    .ADDR_W   (ADDR_W),
    .STS_ADDR (STS_ADDR),
    .CTL_ADDR (CTL_ADDR)
  ) decode_i (
    .addr   (reg_addr),
    .wr     (reg_wr),
    .rd     (reg_rd),
    .sel    (sel),
    .wr_sts (wr_sts),
    .wr_ctl (wr_ctl),
    .rd_sts (rd_sts)
  );

  physt_ovr_bit ovr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ctl (wr_ctl),
    .wbit   (reg_wdata[OVR_BIT]),
    .ovr_q  (ovr_q)
  );

  physt_gated_field #(
    .W (GATED_W)
  ) gated_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sts  (wr_sts),
    .ovr_q   (ovr_q),
    .wfield  (reg_wdata[GATED_MSB:GATED_LSB]),
    .field_q (gated_q)
  );

  physt_done_latch done_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .an_en      (an_enable),
    .an_done    (an_complete),
    .an_restart (an_restart),
    .rd_sts     (rd_sts),
    .done_q     (done_q)
  );

  always_comb begin
    sts_word = FIXED_PART;
    sts_word[GATED_MSB:GATED_LSB] = gated_q;
    sts_word[DONE_BIT] = done_q && an_enable;
  end

  always_comb begin
    ctl_word = '0;
    ctl_word[OVR_BIT] = ovr_q;
  end

  always_comb begin
    unique case (sel)
      SEL_STS: rdata_d = sts_word;
      SEL_CTL: rdata_d = ctl_word;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rdata_d;
    end
  end

  assign pre_suppr_en = gated_q[0];

  AST_BIT5_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == ADDR_W'(STS_ADDR)) && !an_enable) |=> !reg_rdata[DONE_BIT])
    else $error("done bit visible while negotiation disabled"); // R6

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == ADDR_W'(STS_ADDR))) |=> ((reg_rdata & ~LIVE_MASK) == FIXED_PART))
    else $error("fixed status bits disturbed"); // R5

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr != ADDR_W'(STS_ADDR)) && (reg_addr != ADDR_W'(CTL_ADDR))) |=> (reg_rdata == '0))
    else $error("unmapped read returned data"); // R10

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata))
    else $error("read data changed without a read"); // R10

  AST_CTL_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == ADDR_W'(CTL_ADDR))) |=> (reg_rdata[OVR_BIT-1:0] == '0))
    else $error("control register spare bits nonzero"); // R2

endmodule

// File: tb/physt_regfile_tb_top.sv
module physt_regfile_tb_top;

  localparam logic [15:0] FIXED = 16'h7809;
  localparam logic [15:0] VMASK = 16'h07E0;
  localparam logic [4:0]  A_STS = 5'd1;
  localparam logic [4:0]  A_CTL = 5'd16;

  logic        clk;
  logic        rst_n;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        reg_wr;
  logic        reg_rd;
  logic [15:0] reg_rdata;
  logic        an_enable;
  logic        an_complete;
  logic        an_restart;
  logic        pre_suppr_en;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done_run = 0;

  logic        m_ovr;
  logic [4:0]  m_gated;
  logic        m_latch;
  logic [15:0] m_rdata;

  physt_regfile dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_rdata    (reg_rdata),
    .an_enable    (an_enable),
    .an_complete  (an_complete),
    .an_restart   (an_restart),
    .pre_suppr_en (pre_suppr_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] sts_expect(input logic [4:0] g, input logic l, input logic en);
    logic [15:0] w;
    w = FIXED & ~VMASK;
    w[10:6] = g;
    w[5] = l & en;
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic dn, input logic rs, input logic wr,
                      input logic rd, input logic [4:0] a, input logic [15:0] d, input string tag);
    logic live;
    logic [4:0] g_n;
    logic o_n;
    an_enable = en; an_complete = dn; an_restart = rs;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    live = en & dn;
    if (rd) begin
      if (a == A_STS)      m_rdata = sts_expect(m_gated, m_latch, en);
      else if (a == A_CTL) m_rdata = {m_ovr, 15'h0};
      else                 m_rdata = 16'h0;
    end
    o_n = (wr && a == A_CTL) ? d[15] : m_ovr;
    g_n = (wr && a == A_STS && m_ovr) ? d[10:6] : m_gated;
    m_latch = (rd && a == A_STS) ? live : (m_latch | live);
    m_ovr = o_n;
    m_gated = g_n;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; an_restart = 1'b0;
    check(reg_rdata === m_rdata, tag, reg_rdata, m_rdata);
    check(pre_suppr_en === m_gated[0], "R4 pre_suppr_en", {15'h0, pre_suppr_en}, {15'h0, m_gated[0]});
  endtask

  task automatic rd_sts(input logic en, input logic dn, input string tag);
    step(en, dn, 1'b0, 1'b0, 1'b1, A_STS, 16'h0, tag);
  endtask

  initial begin : watchdog
    while (!done_run) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : stim
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    reg_addr = '0; reg_wdata = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    an_enable = 1'b0; an_complete = 1'b0; an_restart = 1'b0;
    m_ovr = 1'b0; m_gated = '0; m_latch = 1'b0; m_rdata = '0;
    repeat (3) @(negedge clk);
    check(reg_rdata === 16'h0, "R1 rdata in reset", reg_rdata, 16'h0);
    check(pre_suppr_en === 1'b0, "R1 pre_suppr_en in reset", {15'h0, pre_suppr_en}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R5: reset image of both registers
    rd_sts(1'b1, 1'b0, "R1 R5 status after reset");
    check(reg_rdata === 16'h7809 & ~16'h0020 & 16'hF81F, "R1 status literal", reg_rdata, 16'h7809);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, A_CTL, 16'h0, "R1 control after reset");
    check(reg_rdata === 16'h0, "R1 control literal", reg_rdata, 16'h0);

    // R3: locked write
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, A_STS, 16'hFFFF, "R3 locked write");
    rd_sts(1'b1, 1'b0, "R3 gated bits unchanged");
    check(reg_rdata[10:6] === 5'h0, "R3 gated literal", reg_rdata, 16'h7809);

    // R2: override flag
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, A_CTL, 16'hFFFF, "R2 set override");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, A_CTL, 16'h0, "R2 read override");
    check(reg_rdata === 16'h8000, "R2 control literal", reg_rdata, 16'h8000);

    // R4 R5: unlocked write
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, A_STS, 16'hFFFF, "R4 unlocked write");
    check(pre_suppr_en === 1'b1, "R4 enable high", {15'h0, pre_suppr_en}, 16'h1);
    rd_sts(1'b1, 1'b0, "R4 R5 status after unlock");
    check(reg_rdata === 16'h7FC9 & ~16'h0020, "R4 R5 status literal", reg_rdata, 16'h7FC9);

    // R7 R8: latch through a drop and restarts
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, A_STS, 16'h0, "R7 completion pulse");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, A_STS, 16'h0, "R8 restart pulse");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, A_STS, 16'h0, "R8 restart pulse");
    rd_sts(1'b1, 1'b0, "R7 R8 latched read");
    check(reg_rdata[5] === 1'b1, "R7 R8 done held", reg_rdata, 16'h0020);
    rd_sts(1'b1, 1'b0, "R9 second read live");
    check(reg_rdata[5] === 1'b0, "R9 done reloaded", reg_rdata, 16'h0);

    // R9: completion in the read cycle
    rd_sts(1'b1, 1'b1, "R9 read with same-cycle set");
    check(reg_rdata[5] === 1'b0, "R9 old value returned", reg_rdata, 16'h0);
    rd_sts(1'b1, 1'b0, "R9 set survives read");
    check(reg_rdata[5] === 1'b1, "R9 same-cycle set kept", reg_rdata, 16'h0020);

    // R6: disabled masks the bit
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, A_STS, 16'h0, "R6 set before disable");
    rd_sts(1'b0, 1'b1, "R6 disabled read");
    check(reg_rdata[5] === 1'b0, "R6 bit5 zero", reg_rdata, 16'h0);

    // R10: unmapped and hold
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd2, 16'h0, "R10 unmapped read");
    check(reg_rdata === 16'h0, "R10 unmapped literal", reg_rdata, 16'h0);
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, A_CTL, 16'h0, "R10 rdata holds");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic en, dn, rs, wr, rd;
      logic [4:0] a;
      int op;
      en = ($urandom % 8) != 0;
      dn = ($urandom % 3) == 0;
      rs = ($urandom % 6) == 0;
      op = $urandom % 6;
      wr = (op == 0) || (op == 1);
      rd = (op >= 2) && (op <= 4);
      case ($urandom % 4)
        0, 1: a = A_STS;
        2: a = A_CTL;
        default: a = 5'($urandom);
      endcase
      step(en, dn, rs, wr, rd, a, 16'($urandom), "R9 R10 random mix");
    end

    done_run = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule